// File: doc/BRIEF.md
# DRAM Strobe Command Decoder

This block is the control logic inside an asynchronous DRAM device. A clock samples the three active-low strobes (row strobe, column strobe, write strobe) and the shared address pins. The block finds the strobe edges by comparing each sample with the one before it. From the order of those edges it classifies every cycle as one of five kinds: a read, a write, a refresh addressed through the pins, a refresh addressed by an internal counter that starts with column-first strobing, or a refresh appended to a preceding access.

Its outputs are the controls that an array and sense logic would consume: a latched row address, a latched column address, a word-line enable, a column-select enable, a write enable and an enable for driving read data. A cycle-kind code reports the classification. The internal refresh row counter supplies the row for every internally addressed refresh. Fast page operation is supported: repeated column strobes under one open row select new columns of that row.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, rowAddr and colAddr are 0, and wordLineEn, colSelEn, writeEn and dataOutEn are all 0. cycleKind is 0 (idle), and the internal refresh row counter is 0.
- R2: A falling row strobe with the column strobe high both before and at that sample latches addrPins into rowAddr. The same edge sets wordLineEn and sets cycleKind to 1 (row open).
- R3: A falling column strobe, sampled while the row strobe was already low and the kind is 1, 2 or 3, has four effects. It latches addrPins into colAddr and sets colSelEn. It sets writeEn to the inverse of weN at that sample. It sets cycleKind to 2 (read) when weN is high, or to 3 (write) when weN is low.
- R4: A read column sets dataOutEn, and a write column clears it. dataOutEn stays set while the column strobe stays low, even across a rising row strobe. It clears on the first sample with the column strobe high. writeEn and dataOutEn are never both set.
- R5: While the row strobe stays low, a rising column strobe clears colSelEn and writeEn. A following falling column strobe latches a new column and access kind without changing rowAddr (fast page).
- R6: When the column strobe is low both before and at a falling row-strobe sample, and no access is being held, the cycle is a counter refresh with cycleKind 4. rowAddr takes the refresh counter value, the address pins are ignored, and colSelEn stays 0.
- R7: When the column strobe has stayed low since a read or write column, or since a previous kind-5 refresh, a rise then fall of the row strobe starts a hidden refresh. It has cycleKind 5 and takes its row from the refresh counter. colAddr is unchanged and dataOutEn keeps its value.
- R8: The refresh counter advances by one on every kind-4 or kind-5 refresh and wraps from NUM_ROWS-1 to 0. Pin-addressed row cycles do not advance it.
- R9: When the row strobe rises after a row was opened with no column, cycleKind is 6 (pin-addressed refresh) for one cycle and then 0. dataOutEn stays 0 throughout.
- R10: A rising row strobe clears wordLineEn, colSelEn and writeEn on the same edge. A read or write kind returns to 0. colSelEn is never set without wordLineEn.
- R11: A falling column strobe during a kind-4 or kind-5 refresh is ignored: colAddr and colSelEn keep their values.
- R12: When both strobes fall in the same sample, the cycle is a normal row open (kind 1, row from pins). The column edge does not select a column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low, taken at the column edge |
| addrPins | input | ADDR_W | Multiplexed row/column address |
| rowAddr | output | ADDR_W | Latched row address |
| colAddr | output | ADDR_W | Latched column address |
| wordLineEn | output | 1 | Selected word line active |
| colSelEn | output | 1 | Column select active |
| writeEn | output | 1 | Write into the selected column |
| dataOutEn | output | 1 | Drive read data out |
| cycleKind | output | 3 | 0 idle, 1 row open, 2 read, 3 write, 4 counter refresh, 5 hidden refresh, 6 pin-addressed refresh |

## Verification
The bench builds the block with ADDR_W = 4 and NUM_ROWS = 12, a row count that is not a power of two. This selects the compare-and-wrap variant of the refresh counter. With only twelve rows, a wrap from row 11 to row 0 occurs after a short chain of refreshes. Those refreshes mix column-first refreshes, hidden refreshes and back-to-back refreshes with the column strobe held low. The bench can therefore confirm that the counter value seen on rowAddr stays consistent across all refresh styles and is untouched by pin-addressed cycles.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE     = 3'd0,
    KIND_ROW_OPEN = 3'd1,
    KIND_READ     = 3'd2,
    KIND_WRITE    = 3'd3,
    KIND_CBR      = 3'd4,
    KIND_HIDDEN   = 3'd5,
    KIND_RAS_ONLY = 3'd6
  } dsdKind_e;

  // Strobes from control to datapath, at most a few set per cycle
  typedef struct packed {
    logic rowFromPins;
    logic rowFromCounter;
    logic colFromPins;
    logic colIsWrite;
    logic rowClose;
    logic casRelease;
  } dsdStrobe_t;

endpackage

// File: rtl/dsd_control.sv
module dsd_control
  import dsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  output dsdStrobe_t strobe,
  output dsdKind_e   kind
);

  logic     rasPrev, casPrev, heldQ, heldD;
  dsdKind_e kindQ, kindD;
  logic     rasFall, rasRise, casFall, casRise, accessKind;

  assign rasFall    = rasPrev & ~rasN;
  assign rasRise    = ~rasPrev & rasN;
  assign casFall    = casPrev & ~casN;
  assign casRise    = ~casPrev & casN;
  assign accessKind = (kindQ == KIND_ROW_OPEN) || (kindQ == KIND_READ) ||
                      (kindQ == KIND_WRITE);

  always_comb begin
    strobe = '0;
    kindD  = kindQ;
    heldD  = heldQ;
    if (kindQ == KIND_RAS_ONLY) kindD = KIND_IDLE;
    if (casRise) begin
      strobe.casRelease = 1'b1;
      heldD = 1'b0;
    end
    if (rasFall) begin
      if (!casPrev && !casN) begin
        // column strobe already low: internally addressed refresh
        strobe.rowFromCounter = 1'b1;
        kindD = heldQ ? KIND_HIDDEN : KIND_CBR;
      end else begin
        strobe.rowFromPins = 1'b1;
        kindD = KIND_ROW_OPEN;
      end
    end else if (rasRise) begin
      strobe.rowClose = 1'b1;
      kindD = (kindQ == KIND_ROW_OPEN) ? KIND_RAS_ONLY : KIND_IDLE;
    end else if (casFall && !rasPrev && !rasN && accessKind) begin
      strobe.colFromPins = 1'b1;
      strobe.colIsWrite  = ~weN;
      kindD = weN ? KIND_READ : KIND_WRITE;
      heldD = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasPrev <= 1'b1;
      casPrev <= 1'b1;
      heldQ   <= 1'b0;
      kindQ   <= KIND_IDLE;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      heldQ   <= heldD;
      kindQ   <= kindD;
    end
  end

  assign kind = kindQ;

endmodule

// File: rtl/dsd_datapath.sv
module dsd_datapath
  import dsd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_ROWS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dsdStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrPins,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              wordLineEn,
  output logic              colSelEn,
  output logic              writeEn,
  output logic              dataOutEn
);

  logic [ADDR_W-1:0] refRow, refNext;

  generate
    if (NUM_ROWS == (1 << ADDR_W)) begin : gPow2Wrap
      assign refNext = refRow + 1'b1;
    end else begin : gCompareWrap
      localparam logic [ADDR_W-1:0] LastRow = ADDR_W'(NUM_ROWS - 1);
      assign refNext = (refRow == LastRow) ? '0 : refRow + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refRow     <= '0;
      rowAddr    <= '0;
      colAddr    <= '0;
      wordLineEn <= 1'b0;
      colSelEn   <= 1'b0;
      writeEn    <= 1'b0;
      dataOutEn  <= 1'b0;
    end else begin
      if (strobe.rowFromPins) begin
        rowAddr    <= addrPins;
        wordLineEn <= 1'b1;
      end
      if (strobe.rowFromCounter) begin
        rowAddr    <= refRow;
        wordLineEn <= 1'b1;
        refRow     <= refNext;
      end
      if (strobe.rowClose) begin
        wordLineEn <= 1'b0;
        colSelEn   <= 1'b0;
        writeEn    <= 1'b0;
      end
      if (strobe.colFromPins) begin
        colAddr   <= addrPins;
        colSelEn  <= 1'b1;
        writeEn   <= strobe.colIsWrite;
        dataOutEn <= ~strobe.colIsWrite;
      end
      if (strobe.casRelease) begin
        colSelEn  <= 1'b0;
        writeEn   <= 1'b0;
        dataOutEn <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int NUM_ROWS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addrPins,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic              wordLineEn,
  output logic              colSelEn,
  output logic              writeEn,
  output logic              dataOutEn,
  output logic [2:0]        cycleKind
);

  dsdStrobe_t strobe;
  dsdKind_e   kind;

  dsd_control u_control (
    .clk    (clk),
    .rst_n  (rst_n),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .strobe (strobe),
    .kind   (kind)
  );

  dsd_datapath #(
    .ADDR_W   (ADDR_W),
    .NUM_ROWS (NUM_ROWS)
  ) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .addrPins   (addrPins),
    .rowAddr    (rowAddr),
    .colAddr    (colAddr),
    .wordLineEn (wordLineEn),
    .colSelEn   (colSelEn),
    .writeEn    (writeEn),
    .dataOutEn  (dataOutEn)
  );

  assign cycleKind = kind;

endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addrPins,
  input logic [ADDR_W-1:0] rowAddr,
  input logic [ADDR_W-1:0] colAddr,
  input logic              wordLineEn,
  input logic              colSelEn,
  input logic              writeEn,
  input logic              dataOutEn,
  input logic [2:0]        cycleKind
);

  assert_row_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rasN) && !rasN && $past(casN) && casN)
    |=> (cycleKind == 3'd1 && wordLineEn && rowAddr == $past(addrPins)));

  assert_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rasN) && !rasN && $past(casN) && !casN &&
     (cycleKind == 3'd1 || cycleKind == 3'd2 || cycleKind == 3'd3))
    |=> (colSelEn && colAddr == $past(addrPins) && writeEn == !$past(weN)));

  assert_data_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(casN) && casN) |=> !dataOutEn);

  assert_write_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    writeEn |-> !dataOutEn);

  assert_refresh_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rasN) && !rasN && !$past(casN) && !casN)
    |=> ((cycleKind == 3'd4 || cycleKind == 3'd5) && wordLineEn && !colSelEn));

  assert_ras_only_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleKind == 3'd6 && rasN) |=> cycleKind == 3'd0);

  assert_row_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rasN) && rasN) |=> (!wordLineEn && !colSelEn && !writeEn));

  assert_colsel_needs_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    colSelEn |-> wordLineEn);

endmodule

bind dram_strobe_decoder dsd_checker #(.ADDR_W(ADDR_W)) u_dsdChecker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .addrPins   (addrPins),
  .rowAddr    (rowAddr),
  .colAddr    (colAddr),
  .wordLineEn (wordLineEn),
  .colSelEn   (colSelEn),
  .writeEn    (writeEn),
  .dataOutEn  (dataOutEn),
  .cycleKind  (cycleKind)
);

// File: tb/tb_dram_strobe_decoder.sv
module tb_dram_strobe_decoder;

  localparam int AW   = 4;
  localparam int ROWS = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addrPins = '0;
  logic [AW-1:0] rowAddr, colAddr;
  logic          wordLineEn, colSelEn, writeEn, dataOutEn;
  logic [2:0]    cycleKind;

  int    nChecks = 0;
  int    nErrors = 0;
  bit    finished = 0;
  string curReq = "R1";

  // reference model state
  int mRasP = 1, mCasP = 1, mHeld = 0, mKind = 0, mRef = 0;
  int mRow = 0, mCol = 0, mWl = 0, mCs = 0, mWe = 0, mDo = 0;

  always #10 clk = ~clk;

  dram_strobe_decoder #(.ADDR_W(AW), .NUM_ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .rasN(rasN), .casN(casN), .weN(weN),
    .addrPins(addrPins), .rowAddr(rowAddr), .colAddr(colAddr),
    .wordLineEn(wordLineEn), .colSelEn(colSelEn), .writeEn(writeEn),
    .dataOutEn(dataOutEn), .cycleKind(cycleKind)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model, advanced once per rising edge and compared after it
  always @(posedge clk) begin
    if (!rst_n) begin
      mRasP = 1; mCasP = 1; mHeld = 0; mKind = 0; mRef = 0;
      mRow = 0; mCol = 0; mWl = 0; mCs = 0; mWe = 0; mDo = 0;
    end else begin
      bit rFell, rRose, cFell, cRose;
      rFell = (mRasP == 1) && !rasN;
      rRose = (mRasP == 0) && rasN;
      cFell = (mCasP == 1) && !casN;
      cRose = (mCasP == 0) && casN;
      if (mKind == 6) mKind = 0;
      if (cRose) begin mCs = 0; mWe = 0; mDo = 0; mHeld = 0; end
      if (rFell) begin
        mWl = 1;
        if (mCasP == 0 && !casN) begin
          mRow = mRef;
          mKind = (mHeld != 0) ? 5 : 4;
          mRef = (mRef + 1) % ROWS;
        end else begin
          mRow = int'(addrPins);
          mKind = 1;
        end
      end else if (rRose) begin
        mWl = 0; mCs = 0; mWe = 0;
        mKind = (mKind == 1) ? 6 : 0;
      end else if (cFell && mRasP == 0 && !rasN && mKind >= 1 && mKind <= 3) begin
        mCol = int'(addrPins); mCs = 1; mHeld = 1;
        mWe = weN ? 0 : 1;
        mDo = weN ? 1 : 0;
        mKind = weN ? 2 : 3;
      end
      mRasP = int'(rasN);
      mCasP = int'(casN);
    end
    #5;
    chk({curReq, " model compare"},
        {17'd0, rowAddr, colAddr, wordLineEn, colSelEn, writeEn, dataOutEn, cycleKind},
        (mRow << 11) | (mCol << 7) | (mWl << 6) | (mCs << 5) | (mWe << 4) | (mDo << 3) | mKind);
  end

  task automatic drive(input bit r, input bit c, input bit w, input int a);
    @(negedge clk);
    rasN = r; casN = c; weN = w; addrPins = AW'(a);
  endtask

  task automatic settle;
    @(posedge clk);
    #6;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("R1 rowAddr", int'(rowAddr), 0);
    chk("R1 colAddr", int'(colAddr), 0);
    chk("R1 enables", int'({wordLineEn, colSelEn, writeEn, dataOutEn}), 0);
    chk("R1 kind", int'(cycleKind), 0);
    rst_n = 1'b1;

    // read with data held across the row strobe rise
    curReq = "R2";
    drive(1, 1, 1, 5); drive(0, 1, 1, 5); settle;
    chk("R2 row", int'(rowAddr), 5);
    chk("R2 wordline", int'(wordLineEn), 1);
    chk("R2 kind", int'(cycleKind), 1);
    curReq = "R3";
    drive(0, 1, 1, 9); drive(0, 0, 1, 9); settle;
    chk("R3 col", int'(colAddr), 9);
    chk("R3 colsel", int'(colSelEn), 1);
    chk("R3 read kind", int'(cycleKind), 2);
    chk("R4 data on", int'(dataOutEn), 1);
    curReq = "R10";
    drive(1, 0, 1, 0); settle;
    chk("R10 wordline off", int'(wordLineEn), 0);
    chk("R10 colsel off", int'(colSelEn), 0);
    chk("R4 data held", int'(dataOutEn), 1);
    curReq = "R4";
    drive(1, 1, 1, 0); settle;
    chk("R4 data released", int'(dataOutEn), 0);

    // write then fast page read
    curReq = "R5";
    drive(0, 1, 1, 3); settle;
    drive(0, 0, 0, 7); settle;
    chk("R3 write kind", int'(cycleKind), 3);
    chk("R3 writeEn", int'(writeEn), 1);
    chk("R4 no data on write", int'(dataOutEn), 0);
    drive(0, 1, 0, 7); settle;
    chk("R5 colsel drop", int'(colSelEn), 0);
    chk("R5 writeEn drop", int'(writeEn), 0);
    drive(0, 0, 1, 12); settle;
    chk("R5 new col", int'(colAddr), 12);
    chk("R5 row kept", int'(rowAddr), 3);
    chk("R5 read kind", int'(cycleKind), 2);
    drive(0, 1, 1, 0); drive(1, 1, 1, 0); settle;
    chk("R10 idle", int'(cycleKind), 0);

    // pin-addressed refresh
    curReq = "R9";
    drive(0, 1, 1, 10); settle;
    chk("R9 row", int'(rowAddr), 10);
    drive(1, 1, 1, 10); settle;
    chk("R9 kind", int'(cycleKind), 6);
    chk("R9 no data", int'(dataOutEn), 0);
    settle;
    chk("R9 back to idle", int'(cycleKind), 0);

    // counter refresh, pins ignored, column edge ignored
    curReq = "R6";
    drive(1, 0, 1, 0); drive(0, 0, 1, 15); settle;
    chk("R6 kind", int'(cycleKind), 4);
    chk("R6 row from counter", int'(rowAddr), 0);
    chk("R6 no colsel", int'(colSelEn), 0);
    curReq = "R11";
    drive(0, 1, 1, 2); drive(0, 0, 1, 2); settle;
    chk("R11 colsel", int'(colSelEn), 0);
    chk("R11 col kept", int'(colAddr), 12);
    drive(1, 1, 1, 0);
    curReq = "R8";
    drive(1, 0, 1, 0); drive(0, 0, 1, 7); settle;
    chk("R8 advanced", int'(rowAddr), 1);
    drive(1, 1, 1, 0);

    // hidden refresh after a read, twice in a row
    curReq = "R7";
    drive(0, 1, 1, 4); drive(0, 0, 1, 6); settle;
    chk("R7 read before", int'(dataOutEn), 1);
    drive(1, 0, 1, 0); drive(0, 0, 1, 8); settle;
    chk("R7 kind", int'(cycleKind), 5);
    chk("R7 row", int'(rowAddr), 2);
    chk("R7 col kept", int'(colAddr), 6);
    chk("R7 data kept", int'(dataOutEn), 1);
    drive(1, 0, 1, 0); drive(0, 0, 1, 8); settle;
    chk("R7 second kind", int'(cycleKind), 5);
    chk("R7 second row", int'(rowAddr), 3);
    drive(1, 1, 1, 0); settle;
    chk("R4 data off after hidden", int'(dataOutEn), 0);

    // repeated counter refresh holding the column strobe low
    curReq = "R6";
    drive(1, 0, 1, 0); drive(0, 0, 1, 0); settle;
    chk("R6 kind", int'(cycleKind), 4);
    chk("R6 row", int'(rowAddr), 4);
    drive(1, 0, 1, 0); drive(0, 0, 1, 0); settle;
    chk("R6 not hidden", int'(cycleKind), 4);
    chk("R6 row next", int'(rowAddr), 5);
    drive(1, 1, 1, 0);

    // counter wrap
    curReq = "R8";
    for (int k = 0; k < 7; k++) begin
      drive(1, 0, 1, 0); drive(0, 0, 1, k + 3); settle;
      chk("R8 wrap sequence", int'(rowAddr), (6 + k) % ROWS);
      drive(1, 1, 1, 0);
    end

    // simultaneous strobe falls
    curReq = "R12";
    drive(1, 1, 1, 0); drive(0, 0, 1, 9); settle;
    chk("R12 kind", int'(cycleKind), 1);
    chk("R12 row", int'(rowAddr), 9);
    chk("R12 no colsel", int'(colSelEn), 0);
    drive(1, 0, 1, 0); settle;
    chk("R12 closes as pin refresh", int'(cycleKind), 6);
    drive(1, 1, 1, 0);
    curReq = "R8";
    drive(1, 0, 1, 0); drive(0, 0, 1, 3); settle;
    chk("R8 not advanced by pin rows", int'(rowAddr), 1);
    drive(1, 1, 1, 0); drive(1, 1, 1, 0); settle;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL %s watchdog: actual 5000 cycles expected completion", curReq);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule